// File: doc/BRIEF.md
# Cartridge IRQ Prescaler-Counter Timer

This block is the interrupt timer of a game-cartridge bank controller. The host CPU programs it through a small register bus: a 3-bit register index, a write strobe and a data byte. A separate one-cycle pulse input, already synchronous to the system clock, supplies the events being counted. Where that pulse comes from is decided outside this block. Internally an 8-bit prescaler feeds an 8-bit counter. The pair counts up or down, and a wrap of the counter raises an active-high interrupt line.

Three register-level oddities are modelled on purpose, because software written for the part relies on them.

- **Load-then-mode nudge.** Loading the prescaler and then writing the mode register moves the prescaler by one.
- **Mask lock.** Turning on the 3-bit prescaler mask right after such a load can freeze the timer. Only a counter reload releases it.
- **End-value hold mode.** This mode separates the counter from the prescaler. The interrupt then follows the counter sitting at its end value, rather than a wrap.

If a register write and a count pulse arrive in the same cycle, the pulse is dropped.

Top module: `cart_irq_timer`

## Requirements
- R1: After reset the IRQ output is low, the prescaler and counter hold 0, the direction is 00 (no counting), the mask and hold mode are off and the IRQ is disabled.
- R2: Register index 3 loads the data byte straight into the live prescaler, and index 4 loads it straight into the live counter. Index 0 is the mode register, 1 is IRQ disable, 2 is IRQ enable and 5 is the hold register (bit 0 = hold mode). Indices 6 and 7 are ignored.
- R3: In the mode register, bit 7 set with bit 6 clear counts down, and bit 6 set counts up; both set counts up. Both clear stops all stepping, and count pulses then leave the prescaler and counter untouched.
- R4: Outside hold mode, each accepted pulse steps the prescaler. Its wrap (0x00 to 0xFF down, 0xFF to 0x00 up) steps the counter, and a counter wrap sets the IRQ if enabled. Counter 0x01 with prescaler 0x05 counting down raises the IRQ on pulse 0x106, as does counter 0xFE with prescaler 0xFA counting up.
- R5: A prescaler load sets a pending flag. The next mode write whose direction bits are 01 or 11 clears the flag and adds one to the prescaler. Direction bits 10 clear the flag and subtract one. Direction bits 00 leave both the flag and the prescaler as they are.
- R6: Mode bit 2 restricts prescaler wrap detection to its low 3 bits: 000 when counting down, 111 when counting up.
- R7: In hold mode an enabled IRQ asserts while the counter equals its end value: 0x00 for down, 0xFF for up, either value for both bits set. Disabling and then re-enabling re-asserts the IRQ while this still holds.
- R8: In hold mode the prescaler keeps stepping on every pulse, but its wraps do not step the counter.
- R9: Writing the hold register with bit 0 clear while hold mode is on steps the counter once in the current direction.
- R10: A mode write with bit 2 set, made while the pending flag is set and the prescaler's low 3 bits are zero, locks the timer. While locked, pulses change nothing. IRQ enable or disable writes do not release the lock; a counter-register write (any value) does.
- R11: A disable write clears both the IRQ output and the enable. An enable write sets the enable and leaves a raised IRQ raised. A counter wrap while disabled is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_idx_i | input | 3 | Register index |
| wr_data_i | input | 8 | Write data byte |
| tick_i | input | 1 | One-cycle count pulse |
| irq_o | output | 1 | Active-high interrupt request |

## Verification
The situation hardest to reach from the ports is the mask lock. It needs three things together: a pending prescaler load, a loaded value whose low three bits are zero, and a later mode write that turns on the mask. The stimulus loads prescaler 0x08 and then writes a masked count-down mode. It sends two thousand pulses, toggles the IRQ enable, and checks that no interrupt ever appears. A counter reload must then restart counting from the nudged prescaler value, and the interrupt must arrive exactly on the sixteenth pulse. Hold release is reached in a similar way: the prescaler is run for 300 pulses while held, so that the interrupt time after release shows both that the prescaler kept stepping and that the counter stepped once.

// File: rtl/cirq_pkg.sv
`timescale 1ns/1ps
package cirq_pkg;
  // register indices on the write bus
  localparam logic [2:0] RI_MODE  = 3'd0;
  localparam logic [2:0] RI_OFF   = 3'd1;
  localparam logic [2:0] RI_ON    = 3'd2;
  localparam logic [2:0] RI_PRESC = 3'd3;
  localparam logic [2:0] RI_COUNT = 3'd4;
  localparam logic [2:0] RI_HOLD  = 3'd5;

  // bit positions inside the mode and hold registers
  localparam int MB_DOWN = 7;
  localparam int MB_UP   = 6;
  localparam int MB_MASK = 2;
  localparam int HB_HOLD = 0;

  typedef struct packed {
    logic down;
    logic up;
  } dir_t;

  function automatic logic dir_active(dir_t d);
    return d.down | d.up;
  endfunction
endpackage

// File: rtl/cirq_ctrl.sv
`timescale 1ns/1ps
module cirq_ctrl
  import cirq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          presc_low_zero,
  output dir_t          dir,
  output logic          mask_en,
  output logic          hold_en,
  output logic          irq_en,
  output logic          irq_off_wr,
  output logic          presc_load,
  output logic          cnt_load,
  output logic [DW-1:0] load_val,
  output logic          nudge_inc,
  output logic          nudge_dec,
  output logic          hold_step,
  output logic          locked
);
  dir_t dir_q, dir_d, wr_dir;
  logic mask_q, mask_d;
  logic hold_q, hold_d;
  logic en_q, en_d;
  logic pend_q, pend_d;
  logic lock_q, lock_d;
  logic mode_wr, on_wr, hold_wr;

  assign mode_wr    = wr_en && (wr_idx == RI_MODE);
  assign on_wr      = wr_en && (wr_idx == RI_ON);
  assign hold_wr    = wr_en && (wr_idx == RI_HOLD);
  assign irq_off_wr = wr_en && (wr_idx == RI_OFF);
  assign presc_load = wr_en && (wr_idx == RI_PRESC);
  assign cnt_load   = wr_en && (wr_idx == RI_COUNT);
  assign load_val   = wr_data;
  assign wr_dir     = {wr_data[MB_DOWN], wr_data[MB_UP]};

  // write-order side effect: direction given by the data being written
  assign nudge_inc = mode_wr && pend_q && wr_dir.up;
  assign nudge_dec = mode_wr && pend_q && wr_dir.down && !wr_dir.up;
  assign hold_step = hold_wr && !wr_data[HB_HOLD] && hold_q && dir_active(dir_q);

  always_comb begin
    dir_d  = dir_q;
    mask_d = mask_q;
    hold_d = hold_q;
    en_d   = en_q;
    pend_d = pend_q;
    lock_d = lock_q;
    if (mode_wr) begin
      dir_d  = wr_dir;
      mask_d = wr_data[MB_MASK];
      if (pend_q && dir_active(wr_dir)) pend_d = 1'b0;
      if (pend_q && wr_data[MB_MASK] && presc_low_zero) lock_d = 1'b1;
    end
    if (presc_load) pend_d = 1'b1;
    if (cnt_load)   lock_d = 1'b0;
    if (hold_wr)    hold_d = wr_data[HB_HOLD];
    if (on_wr)      en_d   = 1'b1;
    if (irq_off_wr) en_d   = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      mask_q <= 1'b0;
      hold_q <= 1'b0;
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      lock_q <= 1'b0;
    end else if (wr_en) begin
      dir_q  <= dir_d;
      mask_q <= mask_d;
      hold_q <= hold_d;
      en_q   <= en_d;
      pend_q <= pend_d;
      lock_q <= lock_d;
    end
  end

  assign dir     = dir_q;
  assign mask_en = mask_q;
  assign hold_en = hold_q;
  assign irq_en  = en_q;
  assign locked  = lock_q;

  // a counter reload always releases the lock
  p_unlock_on_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |=> !locked);
endmodule

// File: rtl/cirq_prescaler.sv
`timescale 1ns/1ps
module cirq_prescaler #(
  parameter int DW     = 8,
  parameter int MASK_W = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          nudge_inc,
  input  logic          nudge_dec,
  input  logic          step,
  input  logic          up,
  input  logic          mask_en,
  output logic [DW-1:0] value,
  output logic          wrap,
  output logic          low_zero
);
  localparam int HI_W = DW - MASK_W;

  logic [DW-1:0]     val_q, val_d;
  logic [MASK_W-1:0] lo;
  logic [HI_W-1:0]   hi;
  logic lo_ones, lo_zero, hi_ones, hi_zero, at_edge, upd;

  assign lo      = val_q[MASK_W-1:0];
  assign hi      = val_q[DW-1:MASK_W];
  assign lo_ones = &lo;
  assign lo_zero = ~|lo;
  assign hi_ones = &hi;
  assign hi_zero = ~|hi;
  // mask removes the upper bits from wrap detection
  assign at_edge = up ? (lo_ones && (mask_en || hi_ones))
                      : (lo_zero && (mask_en || hi_zero));
  assign wrap     = step && at_edge;
  assign low_zero = lo_zero;
  assign upd      = load | nudge_inc | nudge_dec | step;

  always_comb begin
    val_d = val_q;
    if (load)           val_d = load_val;
    else if (nudge_inc) val_d = val_q + 1'b1;
    else if (nudge_dec) val_d = val_q - 1'b1;
    else if (step)      val_d = up ? val_q + 1'b1 : val_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   val_q <= '0;
    else if (upd) val_q <= val_d;
  end

  assign value = val_q;

  p_load_direct_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> value == $past(load_val));
endmodule

// File: rtl/cirq_counter.sv
`timescale 1ns/1ps
module cirq_counter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          step,
  input  logic          up,
  output logic [DW-1:0] value,
  output logic          wrap,
  output logic          at_min,
  output logic          at_max
);
  logic [DW-1:0] cnt_q, cnt_d;
  logic upd;

  assign at_min = ~|cnt_q;
  assign at_max = &cnt_q;
  assign wrap   = step && !load && (up ? at_max : at_min);
  assign upd    = load | step;

  always_comb begin
    cnt_d = cnt_q;
    if (load)      cnt_d = load_val;
    else if (step) cnt_d = up ? cnt_q + 1'b1 : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (upd) cnt_q <= cnt_d;
  end

  assign value = cnt_q;

  p_step_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && up) |=> value == DW'($past(value) + 1'b1));
  p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !up) |=> value == DW'($past(value) - 1'b1));
endmodule

// File: rtl/cart_irq_timer.sv
`timescale 1ns/1ps
module cart_irq_timer
  import cirq_pkg::*;
#(
  parameter int DW     = 8,
  parameter int MASK_W = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [2:0]    wr_idx_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          tick_i,
  output logic          irq_o
);
  dir_t          dir;
  logic          mask_en, hold_en, irq_en, irq_off_wr;
  logic          presc_load, cnt_load, nudge_inc, nudge_dec, hold_step, locked;
  logic [DW-1:0] load_val, presc_val, cnt_val;
  logic          presc_wrap, presc_low_zero, cnt_wrap, at_min, at_max;
  logic          tick_ok, cnt_step, end_hit, irq_q, irq_d;

  cirq_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_idx(wr_idx_i),
    .wr_data(wr_data_i), .presc_low_zero(presc_low_zero), .dir(dir),
    .mask_en(mask_en), .hold_en(hold_en), .irq_en(irq_en),
    .irq_off_wr(irq_off_wr), .presc_load(presc_load), .cnt_load(cnt_load),
    .load_val(load_val), .nudge_inc(nudge_inc), .nudge_dec(nudge_dec),
    .hold_step(hold_step), .locked(locked)
  );

  // a write cycle drops the pulse; a lock or idle direction ignores it
  assign tick_ok = tick_i && !wr_en_i && dir_active(dir) && !locked;

  cirq_prescaler #(.DW(DW), .MASK_W(MASK_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .load(presc_load), .load_val(load_val),
    .nudge_inc(nudge_inc), .nudge_dec(nudge_dec), .step(tick_ok),
    .up(dir.up), .mask_en(mask_en), .value(presc_val), .wrap(presc_wrap),
    .low_zero(presc_low_zero)
  );

  assign cnt_step = (presc_wrap && !hold_en) || hold_step;

  cirq_counter #(.DW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(load_val),
    .step(cnt_step), .up(dir.up), .value(cnt_val), .wrap(cnt_wrap),
    .at_min(at_min), .at_max(at_max)
  );

  always_comb begin
    unique case ({dir.down, dir.up})
      2'b10:   end_hit = at_min;
      2'b01:   end_hit = at_max;
      2'b11:   end_hit = at_min | at_max;
      default: end_hit = 1'b0;
    endcase
  end

  always_comb begin
    irq_d = irq_q;
    if (irq_off_wr)                                     irq_d = 1'b0;
    else if (irq_en && (cnt_wrap || (hold_en && end_hit))) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  p_off_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_idx_i == RI_OFF) |=> !irq_o);
  p_irq_needs_en_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(irq_en));
  p_lock_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !wr_en_i) |=> ($stable(presc_val) && $stable(cnt_val)));
  p_hold_counter_still_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_en && !wr_en_i) |=> $stable(cnt_val));
  p_idle_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_active(dir) && !wr_en_i) |=> ($stable(presc_val) && $stable(cnt_val)));
endmodule

// File: tb/cart_irq_timer_bench.sv
`timescale 1ns/1ps
module cart_irq_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_idx = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic       tick = 1'b0;
  logic       irq;
  int total = 0;
  int bad = 0;

  localparam logic [2:0] I_MODE = 3'd0, I_OFF = 3'd1, I_ON = 3'd2,
                         I_PRESC = 3'd3, I_COUNT = 3'd4, I_HOLD = 3'd5;

  always #2.5 clk = ~clk;

  cart_irq_timer u_cart_irq_timer (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .tick_i(tick), .irq_o(irq)
  );

  task automatic check(input logic act, input logic exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: irq=%b expected %b", req, act, exp);
    end
  endtask

  // every task starts and ends just after a falling edge
  task automatic wr(input logic [2:0] idx, input logic [7:0] d);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic setup(input logic [7:0] mode, input logic hold,
                       input logic [7:0] cnt, input logic [7:0] presc, input logic en);
    wr(I_OFF, 8'h00);
    wr(I_HOLD, 8'h00);
    wr(I_MODE, mode);
    wr(I_HOLD, {7'd0, hold});
    wr(I_COUNT, cnt);
    wr(I_PRESC, presc);
    if (en) wr(I_ON, 8'h00);
  endtask

  // irq must stay low through pulse n-1 and rise on pulse n
  task automatic expect_at(input int n, input string req);
    ticks(n - 1);
    check(irq, 1'b0, req);
    ticks(1);
    check(irq, 1'b1, req);
  endtask

  task automatic t_reset;
    check(irq, 1'b0, "R1 reset");
    wr(I_ON, 8'h00);
    ticks(600);
    check(irq, 1'b0, "R1 idle direction after reset");
  endtask

  task automatic t_chain;
    setup(8'h80, 1'b0, 8'h01, 8'h05, 1'b1);
    expect_at(32'h106, "R4 R2 down chain");
    wr(I_ON, 8'h00);
    check(irq, 1'b1, "R11 enable keeps irq");
    wr(I_OFF, 8'h00);
    check(irq, 1'b0, "R11 disable clears irq");
    setup(8'h40, 1'b0, 8'hFE, 8'hFA, 1'b1);
    expect_at(32'h106, "R4 up chain");
  endtask

  task automatic t_disabled_wrap;
    setup(8'h80, 1'b0, 8'h00, 8'h00, 1'b0);
    ticks(1);
    check(irq, 1'b0, "R11 wrap while disabled");
    wr(I_ON, 8'h00);
    idle(2);
    check(irq, 1'b0, "R11 lost wrap stays lost");
  endtask

  task automatic t_direction;
    setup(8'h00, 1'b0, 8'h01, 8'h05, 1'b1);
    ticks(600);
    check(irq, 1'b0, "R3 direction 00 no count");
    wr(I_MODE, 8'h80);
    expect_at(32'h105, "R3 R5 nothing stepped, then down nudge");
    setup(8'hC0, 1'b0, 8'hFE, 8'hFA, 1'b1);
    wr(I_MODE, 8'hC0);
    expect_at(32'h105, "R3 R5 both bits count up and nudge up");
  endtask

  task automatic t_nudge;
    setup(8'h80, 1'b0, 8'h01, 8'h05, 1'b1);
    wr(I_MODE, 8'h80);
    expect_at(32'h105, "R5 nudge down");
    setup(8'h40, 1'b0, 8'hFE, 8'hFA, 1'b1);
    wr(I_MODE, 8'h40);
    expect_at(32'h105, "R5 nudge up");
    setup(8'h80, 1'b0, 8'h01, 8'h05, 1'b1);
    wr(I_MODE, 8'h00);
    wr(I_MODE, 8'h80);
    wr(I_MODE, 8'h80);
    expect_at(32'h105, "R5 00 keeps flag, nudge only once");
  endtask

  task automatic t_mask;
    setup(8'h84, 1'b0, 8'h01, 8'h13, 1'b1);
    expect_at(12, "R6 masked down");
    setup(8'h44, 1'b0, 8'hFF, 8'h13, 1'b1);
    expect_at(5, "R6 masked up");
  endtask

  task automatic t_hold;
    setup(8'h80, 1'b1, 8'h00, 8'h00, 1'b1);
    idle(1);
    check(irq, 1'b1, "R7 hold down at 00");
    wr(I_OFF, 8'h00);
    check(irq, 1'b0, "R7 R11 disable in hold");
    wr(I_ON, 8'h00);
    idle(1);
    check(irq, 1'b1, "R7 re-enable re-asserts");
    setup(8'h40, 1'b1, 8'hFF, 8'h00, 1'b1);
    idle(1);
    check(irq, 1'b1, "R7 hold up at FF");
    setup(8'hC0, 1'b1, 8'h00, 8'h00, 1'b1);
    idle(1);
    check(irq, 1'b1, "R7 hold both at 00");
    setup(8'h80, 1'b1, 8'hFF, 8'h00, 1'b1);
    idle(2);
    check(irq, 1'b0, "R7 hold down not at end");
  endtask

  task automatic t_hold_release;
    // prescaler 0 runs 300 pulses down to 0xD4 while the counter stays at 5
    setup(8'h80, 1'b1, 8'h05, 8'h00, 1'b1);
    ticks(300);
    check(irq, 1'b0, "R8 no counter step in hold");
    wr(I_HOLD, 8'h00);
    // counter now 4: wraps at 213 + 4*256
    expect_at(1237, "R8 R9 prescaler kept stepping, release stepped once");
  endtask

  task automatic t_lock;
    setup(8'h80, 1'b0, 8'h01, 8'h08, 1'b1);
    wr(I_MODE, 8'h84);
    ticks(2000);
    check(irq, 1'b0, "R10 locked");
    wr(I_OFF, 8'h00);
    wr(I_ON, 8'h00);
    ticks(600);
    check(irq, 1'b0, "R10 enable toggles keep lock");
    wr(I_COUNT, 8'h01);
    expect_at(16, "R10 counter write unlocks");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL all: watchdog expired, irq=%b expected completion", irq);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_chain();
    t_disabled_wrap();
    t_direction();
    t_nudge();
    t_mask();
    t_hold();
    t_hold_release();
    t_lock();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule